// File: doc/BRIEF.md
# Single-Entry Posted Write Buffer

This block sits inside a bus controller, between the internal bus, which the CPU and a DMA master share, and a slow external memory port. An external write from either master is captured into one address, data and byte-enable register and acknowledged in the same cycle. The master can then move on while the captured write drains through the external port at the memory's pace. A busy flag marks the entry as occupied.

While the entry drains, accesses decoded as on-chip go straight to the on-chip port and finish at that port's own speed, so they can overtake the pending external write. External reads are never posted. Any external read waits until the buffered write has finished, whatever its address. The external port therefore never reorders, and a dummy read of the written address tells software that the write has landed. A second external write that arrives while the entry is occupied stalls until the entry frees. A new write may be accepted in the same cycle the external port reports the old one complete.

The same rules hold for a DMA master. In a dual-address transfer, a read from on-chip space may start while the previous external write is still draining. When both source and destination are external, the next external read waits for the previous write, so the next write cannot begin before that write has completed.

Top module: `posted_wr_buf`

## Requirements
- R1: After reset the buffer is empty (`wb_busy`=0), `x_req`=0 and `o_req`=0, and `m_ready`=0 while no request is presented.
- R2: An external write presented while the buffer is empty gets `m_ready`=1 in that same cycle. From the next cycle, `wb_busy`=1 and the external port shows `x_req`=1 and `x_we`=1 with the captured address, data and byte enables.
- R3: While `wb_busy`=1 and `x_ready`=0, the external port keeps `x_req`=1, `x_we`=1 and the same address, data and byte enables.
- R4: `wb_busy` goes to 0 at the clock edge where `x_ready`=1 completes the buffered write. If an external write is presented in that completion cycle, it is acknowledged (`m_ready`=1) in that cycle and becomes the new entry.
- R5: An external write presented while `wb_busy`=1 and `x_ready`=0 gets `m_ready`=0, and the buffered entry is unchanged.
- R6: An on-chip access presented while `wb_busy`=1 is forwarded at once on `o_req`. Its `m_ready` and `m_rdata` follow `o_ready` and `o_rdata`, and the external port keeps driving the buffered write.
- R7: An external read to any address presented while `wb_busy`=1 gets `m_ready`=0, and the external port keeps `x_we`=1 for the buffered write.
- R8: An external read presented while the buffer is empty drives `x_req`=1, `x_we`=0, `x_addr`=`m_addr`. Its `m_ready` and `m_rdata` follow `x_ready` and `x_rdata`.
- R9: A read to the same address as the buffered write gets no `m_ready` in the cycle that write completes. It is served in a later cycle, as an external read.
- R10: An address is external when (`m_addr` & `EXT_MASK`) == `EXT_BASE`, and on-chip otherwise. An on-chip write reaches only `o_req` (`x_req` stays 0) and leaves `wb_busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master access request |
| m_we | input | 1 | 1 = write, 0 = read |
| m_addr | input | AW | Master address |
| m_wdata | input | DW | Master write data |
| m_be | input | BW | Master byte enables |
| m_ready | output | 1 | Access accepted or read data valid |
| m_rdata | output | DW | Read data to master |
| o_req | output | 1 | On-chip port request |
| o_we | output | 1 | On-chip port write |
| o_addr | output | AW | On-chip port address |
| o_wdata | output | DW | On-chip port write data |
| o_be | output | BW | On-chip port byte enables |
| o_ready | input | 1 | On-chip port completion |
| o_rdata | input | DW | On-chip port read data |
| x_req | output | 1 | External port request |
| x_we | output | 1 | External port write |
| x_addr | output | AW | External port address |
| x_wdata | output | DW | External port write data |
| x_be | output | BW | External port byte enables |
| x_ready | input | 1 | External port completion |
| x_rdata | input | DW | External port read data |
| wb_busy | output | 1 | Buffer entry occupied |

## Verification
The bench builds the block with 32-bit address and data, four byte enables, and `EXT_BASE` = `EXT_MASK` = 0x8000_0000, so the top address bit picks external space. The bench drives `x_ready` itself, so it can hold a buffered write for several cycles. That lets it put on-chip accesses, stalled writes and stalled reads against the draining entry, and release a new write in the exact completion cycle. A scoreboard pairs every acknowledged external write with the write later completed on the external port, which confirms both order and content.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    RT_IDLE   = 2'd0,
    RT_ONCHIP = 2'd1,
    RT_EXT_WR = 2'd2,
    RT_EXT_RD = 2'd3
  } route_e;
endpackage

// File: rtl/pwb_decode.sv
module pwb_decode
  import pwb_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] EXT_BASE = '0,
  parameter logic [AW-1:0] EXT_MASK = '0
) (
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output route_e        route
);
  logic is_ext;

  always_comb begin
    is_ext = ((addr & EXT_MASK) == EXT_BASE);
    if (!req)        route = RT_IDLE;
    else if (!is_ext) route = RT_ONCHIP;
    else if (we)      route = RT_EXT_WR;
    else              route = RT_EXT_RD;
  end
endmodule

// File: rtl/pwb_entry.sv
module pwb_entry #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          done,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [BW-1:0] in_be,
  output logic          busy,
  output logic [AW-1:0] e_addr,
  output logic [DW-1:0] e_data,
  output logic [BW-1:0] e_be
);
  logic busy_d;

  always_comb begin
    busy_d = busy;
    if (done) busy_d = 1'b0;
    if (load) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_addr <= '0;
      e_data <= '0;
      e_be   <= '0;
    end else if (load) begin
      e_addr <= in_addr;
      e_data <= in_data;
      e_be   <= in_be;
    end
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy && e_addr == $past(in_addr) && e_data == $past(in_data) && e_be == $past(in_be));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && !load |=> busy && $stable(e_addr) && $stable(e_data) && $stable(e_be));

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load |=> !busy);
endmodule

// File: rtl/pwb_route.sv
module pwb_route
  import pwb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  route_e        route,
  input  logic          busy,
  input  logic [AW-1:0] e_addr,
  input  logic [DW-1:0] e_data,
  input  logic [BW-1:0] e_be,
  input  logic          m_we,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  input  logic [BW-1:0] m_be,
  input  logic          o_ready,
  input  logic [DW-1:0] o_rdata,
  input  logic          x_ready,
  input  logic [DW-1:0] x_rdata,
  output logic          m_ready,
  output logic [DW-1:0] m_rdata,
  output logic          load,
  output logic          done,
  output logic          o_req,
  output logic          o_we,
  output logic [AW-1:0] o_addr,
  output logic [DW-1:0] o_wdata,
  output logic [BW-1:0] o_be,
  output logic          x_req,
  output logic          x_we,
  output logic [AW-1:0] x_addr,
  output logic [DW-1:0] x_wdata,
  output logic [BW-1:0] x_be
);
  logic rd_go;

  always_comb begin
    done  = busy && x_ready;
    load  = (route == RT_EXT_WR) && (!busy || x_ready);
    rd_go = (route == RT_EXT_RD) && !busy;

    o_req   = (route == RT_ONCHIP);
    o_we    = m_we;
    o_addr  = m_addr;
    o_wdata = m_wdata;
    o_be    = m_be;

    x_req   = busy || rd_go;
    x_we    = busy;
    x_addr  = busy ? e_addr : m_addr;
    x_wdata = e_data;
    x_be    = busy ? e_be : m_be;

    unique case (route)
      RT_ONCHIP: m_ready = o_ready;
      RT_EXT_WR: m_ready = load;
      RT_EXT_RD: m_ready = rd_go && x_ready;
      default:   m_ready = 1'b0;
    endcase
    m_rdata = (route == RT_ONCHIP) ? o_rdata : x_rdata;
  end
endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf
  import pwb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = DW / 8,
  parameter logic [AW-1:0] EXT_BASE = {1'b1, {(AW-1){1'b0}}},
  parameter logic [AW-1:0] EXT_MASK = {1'b1, {(AW-1){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_req,
  input  logic          m_we,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  input  logic [BW-1:0] m_be,
  output logic          m_ready,
  output logic [DW-1:0] m_rdata,
  output logic          o_req,
  output logic          o_we,
  output logic [AW-1:0] o_addr,
  output logic [DW-1:0] o_wdata,
  output logic [BW-1:0] o_be,
  input  logic          o_ready,
  input  logic [DW-1:0] o_rdata,
  output logic          x_req,
  output logic          x_we,
  output logic [AW-1:0] x_addr,
  output logic [DW-1:0] x_wdata,
  output logic [BW-1:0] x_be,
  input  logic          x_ready,
  input  logic [DW-1:0] x_rdata,
  output logic          wb_busy
);
  route_e        route;
  logic          load, done;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_data;
  logic [BW-1:0] e_be;

  pwb_decode #(.AW(AW), .EXT_BASE(EXT_BASE), .EXT_MASK(EXT_MASK)) u_decode (
    .req(m_req), .we(m_we), .addr(m_addr), .route(route)
  );

  pwb_entry #(.AW(AW), .DW(DW), .BW(BW)) u_entry (
    .clk(clk), .rst_n(rst_n), .load(load), .done(done),
    .in_addr(m_addr), .in_data(m_wdata), .in_be(m_be),
    .busy(wb_busy), .e_addr(e_addr), .e_data(e_data), .e_be(e_be)
  );

  pwb_route #(.AW(AW), .DW(DW), .BW(BW)) u_route (
    .route(route), .busy(wb_busy), .e_addr(e_addr), .e_data(e_data), .e_be(e_be),
    .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be),
    .o_ready(o_ready), .o_rdata(o_rdata), .x_ready(x_ready), .x_rdata(x_rdata),
    .m_ready(m_ready), .m_rdata(m_rdata), .load(load), .done(done),
    .o_req(o_req), .o_we(o_we), .o_addr(o_addr), .o_wdata(o_wdata), .o_be(o_be),
    .x_req(x_req), .x_we(x_we), .x_addr(x_addr), .x_wdata(x_wdata), .x_be(x_be)
  );

  assert_read_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RT_EXT_RD) && wb_busy |-> !m_ready && x_we);

  assert_full_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RT_EXT_WR) && wb_busy && !x_ready |-> !m_ready);

  assert_drain_continues_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_busy && !x_ready |=> x_req && x_we);

  assert_onchip_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    o_req |-> !(x_req && !x_we));
endmodule

// File: tb/posted_wr_buf_bench.sv
module posted_wr_buf_bench;
  localparam int CLK_P = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          m_req, m_we;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata;
  logic [BW-1:0] m_be;
  logic          m_ready;
  logic [DW-1:0] m_rdata;
  logic          o_req, o_we;
  logic [AW-1:0] o_addr;
  logic [DW-1:0] o_wdata;
  logic [BW-1:0] o_be;
  logic          o_ready;
  logic [DW-1:0] o_rdata;
  logic          x_req, x_we;
  logic [AW-1:0] x_addr;
  logic [DW-1:0] x_wdata;
  logic [BW-1:0] x_be;
  logic          x_ready;
  logic [DW-1:0] x_rdata;
  logic          wb_busy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [AW+DW+BW-1:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  posted_wr_buf #(.AW(AW), .DW(DW), .BW(BW),
                  .EXT_BASE(32'h8000_0000), .EXT_MASK(32'h8000_0000)) u_posted_wr_buf (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_be(m_be), .m_ready(m_ready), .m_rdata(m_rdata),
    .o_req(o_req), .o_we(o_we), .o_addr(o_addr), .o_wdata(o_wdata), .o_be(o_be),
    .o_ready(o_ready), .o_rdata(o_rdata), .x_req(x_req), .x_we(x_we),
    .x_addr(x_addr), .x_wdata(x_wdata), .x_be(x_be), .x_ready(x_ready),
    .x_rdata(x_rdata), .wb_busy(wb_busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic look();
    @(negedge clk);
  endtask

  task automatic idle();
    m_req = 0; m_we = 0; m_addr = '0; m_wdata = '0; m_be = '0;
  endtask

  task automatic drive(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be);
    m_req = 1; m_we = we; m_addr = a; m_wdata = d; m_be = be;
  endtask

  // Driver side of the scoreboard: an acknowledged external write is expected later on x_*
  task automatic expect_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be);
    exp_q.push_back({a, d, be});
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor side: every completed external write is compared with the oldest expected one
  always @(negedge clk) begin
    if (rst_n && x_req && x_we && x_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected external write", {32'h0, x_addr}, 64'h0);
      end else begin
        logic [AW+DW+BW-1:0] e;
        e = exp_q.pop_front();
        chk({x_addr, x_wdata, x_be} == e, "R2 drained write content/order",
            {x_addr, x_wdata}, e[AW+DW+BW-1:BW]);
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 0; o_ready = 0; o_rdata = '0; x_ready = 0; x_rdata = '0;
    idle();
    repeat (3) @(posedge clk);
    #(CLK_P/4); rst_n = 1;

    // R1
    look();
    chk(wb_busy == 0, "R1 busy", wb_busy, 0);
    chk(x_req == 0, "R1 x_req", x_req, 0);
    chk(o_req == 0 && m_ready == 0, "R1 o_req/m_ready", {o_req, m_ready}, 0);

    // R2: posted write into empty buffer
    step(); drive(1, 32'h8000_0010, 32'hA5A5_0001, 4'b1111);
    look();
    chk(m_ready == 1, "R2 same-cycle ack", m_ready, 1);
    expect_wr(32'h8000_0010, 32'hA5A5_0001, 4'b1111);
    step(); idle();
    look();
    chk(wb_busy == 1 && x_req == 1 && x_we == 1, "R2 entry on port", {wb_busy, x_req, x_we}, 3'b111);
    chk(x_addr == 32'h8000_0010 && x_be == 4'b1111, "R2 addr/be", x_addr, 32'h8000_0010);

    // R3: held while not ready
    for (int i = 0; i < 3; i++) begin
      step(); look();
      chk(x_req && x_we && x_addr == 32'h8000_0010 && x_wdata == 32'hA5A5_0001,
          "R3 hold", x_addr, 32'h8000_0010);
    end

    // R6: on-chip read overtakes draining write
    step(); drive(0, 32'h0000_0100, '0, 4'b1111); o_ready = 1; o_rdata = 32'h1234_5678;
    look();
    chk(o_req == 1 && o_we == 0 && o_addr == 32'h0000_0100, "R6 on-chip forwarded", o_req, 1);
    chk(m_ready == 1 && m_rdata == 32'h1234_5678, "R6 on-chip data", m_rdata, 32'h1234_5678);
    chk(x_req && x_we && x_addr == 32'h8000_0010, "R6 ext still draining", x_addr, 32'h8000_0010);

    // R5: second external write stalls
    step(); o_ready = 0; drive(1, 32'h8000_0020, 32'hB6B6_0002, 4'b0011);
    look();
    chk(m_ready == 0, "R5 stall when full", m_ready, 0);
    chk(x_addr == 32'h8000_0010 && x_be == 4'b1111, "R5 entry unchanged", x_addr, 32'h8000_0010);

    // R4: completion cycle accepts the waiting write
    step(); x_ready = 1;
    look();
    chk(m_ready == 1, "R4 accept in completion cycle", m_ready, 1);
    expect_wr(32'h8000_0020, 32'hB6B6_0002, 4'b0011);
    step(); x_ready = 0; idle();
    look();
    chk(wb_busy == 1 && x_addr == 32'h8000_0020 && x_be == 4'b0011, "R4 new entry", x_addr, 32'h8000_0020);

    // R7: read to a different external address waits
    step(); drive(0, 32'h8000_0400, '0, 4'b1111);
    look();
    chk(m_ready == 0 && x_we == 1, "R7 other-address read stalls", {m_ready, x_we}, 2'b01);

    // R9: same-address dummy read waits through completion
    step(); drive(0, 32'h8000_0020, '0, 4'b1111);
    look();
    chk(m_ready == 0 && x_we == 1, "R9 dummy read stalls", {m_ready, x_we}, 2'b01);
    step(); x_ready = 1; x_rdata = 32'hDEAD_BEEF;
    look();
    chk(m_ready == 0, "R9 no ack in completion cycle", m_ready, 0);
    step();
    look();
    chk(wb_busy == 0, "R4 busy cleared", wb_busy, 0);
    chk(x_req == 1 && x_we == 0 && x_addr == 32'h8000_0020, "R9 read issued after write", {x_req, x_we}, 2'b10);
    chk(m_ready == 1 && m_rdata == 32'hDEAD_BEEF, "R9 read data", m_rdata, 32'hDEAD_BEEF);

    // R8: external read on empty buffer with latency
    step(); x_ready = 0; drive(0, 32'h8000_0800, '0, 4'b0001);
    look();
    chk(x_req == 1 && x_we == 0 && x_addr == 32'h8000_0800 && x_be == 4'b0001, "R8 read on port", x_addr, 32'h8000_0800);
    chk(m_ready == 0, "R8 waits for x_ready", m_ready, 0);
    step(); x_ready = 1; x_rdata = 32'h0BAD_F00D;
    look();
    chk(m_ready == 1 && m_rdata == 32'h0BAD_F00D, "R8 read data", m_rdata, 32'h0BAD_F00D);

    // R10: on-chip write bypasses the buffer
    step(); x_ready = 0; drive(1, 32'h7FFF_FFFC, 32'h5555_AAAA, 4'b1000); o_ready = 1;
    look();
    chk(o_req == 1 && o_we == 1 && o_wdata == 32'h5555_AAAA, "R10 on-chip write", o_req, 1);
    chk(x_req == 0 && m_ready == 1, "R10 ext port quiet", x_req, 0);
    step(); idle(); o_ready = 0;
    look();
    chk(wb_busy == 0, "R10 buffer still empty", wb_busy, 0);

    step();
    chk(exp_q.size() == 0, "R2 all posted writes drained", exp_q.size(), 0);
    report();
  end
endmodule